// File: doc/BRIEF.md
# Fractional-N Clock Divider with Cascaded Modulo-M Dither

The block divides a fast input clock by a ratio that can change from one output period to the next. Over many periods the ratio averages exactly N + F/M. A cascade of up to three first-order accumulators, each working modulo M, produces a signed offset ΔN once per output period. The divider counter reloads with N + ΔN at its terminal count and emits a one-cycle pulse there. M can be any integer from 2 to 2^W−1, so the fraction is not tied to a power of two. The order is selectable from 1 to 3. Higher orders push the dither error towards high offset frequencies, where a downstream loop filter removes it. In exchange, the instantaneous ratio spreads wider.

Configuration inputs are sampled only at a period boundary. A new configuration restarts the modulator from a clean state. An illegal configuration is refused, an error flag is raised, and the running configuration continues unchanged.

Top module: `fracn_mash_div`

## Requirements
- R1: While reset is held, and at the first sampling after release, `div_pulse`, `delta_n` and `cfg_err` are all 0. With a legal configuration on the inputs at release, the first pulse comes exactly N clocks after the first rising edge that follows release.
- R2: `div_pulse` is high for one clock. The interval from one pulse to the next is N + ΔN clocks. The ΔN used for that period is shown on `delta_n` (4-bit two's complement) from the clock after the pulse until the next pulse.
- R3: With `order` = 1, ΔN is 0 or 1. In every run of K·M periods after a configuration has been applied, exactly K·F periods last N+1 clocks. For example, N=5, F=1, M=100 gives 99 periods of 5 and one period of 6.
- R4: Each stage keeps a residue r below M. On each step it forms s = r + x. If s ≥ M, it stores s − M and carries 1; otherwise it stores s and carries 0. Stage 1 takes x = F. Each later stage takes the residue that the stage before it has just stored. ΔN = c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' and '' mark the carries of the previous step and of the step before that. Stages above the selected order contribute 0.
- R5: ΔN stays in −1..+2 with `order` = 2 and in −3..+4 with `order` = 3.
- R6: Over P periods following an applied configuration, with P a multiple of M, the total clock count minus (P/M)·(M·N+F) is 0 for order 1, 0..1 for order 2 and −1..+2 for order 3.
- R7: Inputs are sampled only at the clock edge that follows a pulse. A legal configuration that differs from the running one is then applied: the next period lasts exactly N clocks, `delta_n` shows 0, and all residues and carry history are cleared.
- R8: A configuration is illegal when `order` is 0, M < 2, F ≥ M, or N < 2 + (3, 1 or 0 for order 3, 2 or 1). When such a configuration is sampled, `cfg_err` goes high for the period that follows. The running configuration continues as if unchanged. `cfg_err` returns to 0 at the first boundary that samples a legal configuration.
- R9: When a boundary samples the running configuration again, the modulator continues from its state and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| n_int | input | NW | Integer part N of the ratio |
| f_num | input | W | Fraction numerator F |
| m_mod | input | W | Fraction modulus M |
| order | input | 2 | Modulator order, 1 to 3 (0 is illegal) |
| div_pulse | output | 1 | One-clock pulse at each period boundary |
| delta_n | output | 4 | Signed ΔN of the current period |
| cfg_err | output | 1 | Last sampled configuration was refused |

## Verification
The exact long-run total only appears at the end of a full window of M·K steps that begins at a clean restart. A window can be closed early by a configuration change, and with a large modulus it is very long. The stimulus holds each configuration across complete windows, including a 100-period first-order run and a modulus at 2^W−1. Random configuration changes land at arbitrary clocks inside a period. Illegal configurations are injected while a legal one runs, to show that the refusal leaves the modulator state untouched.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   // width of the signed per-period offset
   localparam int DN_W      = 4;
   // number of cascaded stages available
   localparam int MAX_ORDER = 3;
   // shortest period the counter may ever be loaded with
   localparam int MIN_PERIOD = 2;

   typedef logic signed [DN_W-1:0] dn_t;

   // magnitude of the most negative offset each order can produce
   function automatic int dn_floor(input logic [1:0] ord);
      case (ord)
         2'd2:    return 1;
         2'd3:    return 3;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/fracn_mash_stage.sv
module fracn_mash_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic         en,
   input  logic [W-1:0] m,
   input  logic [W-1:0] x,
   output logic [W-1:0] res_nxt,
   output logic         carry
);
   localparam int SW = W + 1;

   logic [W-1:0]  acc;
   logic [SW-1:0] sum;
   logic [SW-1:0] dif;

   always_comb begin
      sum     = {1'b0, acc} + {1'b0, x};
      dif     = sum - {1'b0, m};
      carry   = en && (sum >= {1'b0, m});
      if (!en)
         res_nxt = '0;
      else if (carry)
         res_nxt = dif[W-1:0];
      else
         res_nxt = sum[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (adv)
         acc <= res_nxt;
   end

   // R4
   resid_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (acc < m));

   // R4
   idle_stage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !carry) |=> (acc == '0) || $past(!adv));
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
   import fracn_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [1:0]   ord,
   input  logic [W-1:0] f,
   input  logic [W-1:0] m,
   output dn_t          dn_nxt
);
   localparam int ST = MAX_ORDER;

   if (ST != 3) begin : g_bad_order
      $error("fracn_mash: combiner is written for three stages");
   end

   logic [W-1:0]  res [ST];
   logic [ST-1:0] cy;
   logic          c2d, c3d, c3dd;

   for (genvar k = 0; k < ST; k++) begin : g_stage
      logic [W-1:0] x_k;
      logic         en_k;
      if (k == 0) begin : g_head
         assign x_k = f;
      end else begin : g_tail
         assign x_k = res[k-1];
      end
      assign en_k = (int'(ord) > k);
      fracn_mash_stage #(.W(W)) u_st (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .adv     (adv),
         .en      (en_k),
         .m       (m),
         .x       (x_k),
         .res_nxt (res[k]),
         .carry   (cy[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         c2d  <= 1'b0;
         c3d  <= 1'b0;
         c3dd <= 1'b0;
      end else if (adv) begin
         c2d  <= cy[1];
         c3d  <= cy[2];
         c3dd <= c3d;
      end
   end

   always_comb begin
      dn_nxt = dn_t'({3'b000, cy[0]})
             + dn_t'({3'b000, cy[1]}) - dn_t'({3'b000, c2d})
             + dn_t'({3'b000, cy[2]}) - dn_t'({2'b00, c3d, 1'b0})
             + dn_t'({3'b000, c3dd});
   end

   // R5
   dn_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (dn_nxt >= -4'sd3) && (dn_nxt <= 4'sd4));

   // R5
   dn_ord2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ord == 2'd2) |-> (dn_nxt >= -4'sd1) && (dn_nxt <= 4'sd2));

   // R3
   dn_ord1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ord == 2'd1) |-> (dn_nxt == 4'sd0) || (dn_nxt == 4'sd1));

   // R7
   hist_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !c2d && !c3d && !c3dd);
endmodule

// File: rtl/fracn_cfg_gate.sv
module fracn_cfg_gate
   import fracn_pkg::*;
#(
   parameter int NW = 8,
   parameter int W  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tc,
   input  logic [NW-1:0] n_in,
   input  logic [W-1:0]  f_in,
   input  logic [W-1:0]  m_in,
   input  logic [1:0]    ord_in,
   output logic [NW-1:0] act_n,
   output logic [W-1:0]  act_f,
   output logic [W-1:0]  act_m,
   output logic [1:0]    act_ord,
   output logic          act_vld,
   output logic          apply,
   output logic          cfg_err
);
   logic [NW-1:0] n_floor;
   logic          cand_ok;
   logic          differs;

   always_comb begin
      n_floor = NW'(MIN_PERIOD + dn_floor(ord_in));
      cand_ok = (ord_in != 2'd0) && (m_in >= W'(2)) && (f_in < m_in)
             && (n_in >= n_floor);
      differs = !act_vld || (n_in != act_n) || (f_in != act_f)
             || (m_in != act_m) || (ord_in != act_ord);
      apply   = tc && cand_ok && differs;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_n   <= '0;
         act_f   <= '0;
         act_m   <= '0;
         act_ord <= '0;
         act_vld <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         if (tc)
            cfg_err <= !cand_ok;
         if (apply) begin
            act_n   <= n_in;
            act_f   <= f_in;
            act_m   <= m_in;
            act_ord <= ord_in;
            act_vld <= 1'b1;
         end
      end
   end

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tc |=> $stable({act_n, act_f, act_m, act_ord}));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tc |=> $stable(cfg_err));

   // R8
   refused_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !cand_ok) |=> $stable({act_n, act_f, act_m, act_ord}) && cfg_err);
endmodule

// File: rtl/fracn_div_cnt.sv
module fracn_div_cnt #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] ld_val,
   output logic          tc
);
   logic [CW-1:0] cnt;

   assign tc = (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= CW'(1);
      else if (tc) begin
         if (load)
            cnt <= ld_val;
      end else
         cnt <= cnt - CW'(1);
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tc |=> cnt == $past(cnt) - CW'(1));

   // R2
   reload_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && load) |=> cnt >= CW'(2));
endmodule

// File: rtl/fracn_mash_div.sv
module fracn_mash_div
   import fracn_pkg::*;
#(
   parameter int NW = 8,
   parameter int W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NW-1:0]         n_int,
   input  logic [W-1:0]          f_num,
   input  logic [W-1:0]          m_mod,
   input  logic [1:0]            order,
   output logic                  div_pulse,
   output logic signed [DN_W-1:0] delta_n,
   output logic                  cfg_err
);
   localparam int CW = NW + 1;

   if (NW < 3) begin : g_bad_nw
      $error("fracn_mash_div: NW must hold the largest minimum N");
   end
   if (W < 2) begin : g_bad_w
      $error("fracn_mash_div: W must allow a modulus of at least 2");
   end

   logic          tc, apply, act_vld, adv, load;
   logic [NW-1:0] act_n;
   logic [W-1:0]  act_f, act_m;
   logic [1:0]    act_ord;
   dn_t           dn_nxt;
   logic [CW-1:0] ld_val;
   logic signed [CW:0] step_sum;

   fracn_cfg_gate #(.NW(NW), .W(W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .tc      (tc),
      .n_in    (n_int),
      .f_in    (f_num),
      .m_in    (m_mod),
      .ord_in  (order),
      .act_n   (act_n),
      .act_f   (act_f),
      .act_m   (act_m),
      .act_ord (act_ord),
      .act_vld (act_vld),
      .apply   (apply),
      .cfg_err (cfg_err)
   );

   assign adv  = tc && act_vld && !apply;
   assign load = apply || adv;

   fracn_mash #(.W(W)) u_mash (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (apply),
      .adv    (adv),
      .ord    (act_ord),
      .f      (act_f),
      .m      (act_m),
      .dn_nxt (dn_nxt)
   );

   always_comb begin
      step_sum = $signed({2'b00, act_n})
               + $signed({{(CW + 1 - DN_W){dn_nxt[DN_W-1]}}, dn_nxt});
      ld_val   = apply ? {1'b0, n_int} : step_sum[CW-1:0];
   end

   fracn_div_cnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .ld_val (ld_val),
      .tc     (tc)
   );

   assign div_pulse = tc && act_vld;

   always_ff @(posedge clk) begin
      if (!rst_n || apply)
         delta_n <= '0;
      else if (adv)
         delta_n <= dn_nxt;
   end

   // R2
   dn_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_pulse |=> $stable(delta_n));

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R7
   apply_zero_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> delta_n == '0);
endmodule

// File: tb/fracn_mash_div_tb.sv
module fracn_mash_div_tb;
   localparam int WDOG = 190000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        n_int = 8'd5;
   logic [7:0]        f_num = 8'd1;
   logic [7:0]        m_mod = 8'd100;
   logic [1:0]        order = 2'd1;
   logic              div_pulse;
   logic signed [3:0] delta_n;
   logic              cfg_err;

   always #4 clk = ~clk;

   fracn_mash_div u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .n_int     (n_int),
      .f_num     (f_num),
      .m_mod     (m_mod),
      .order     (order),
      .div_pulse (div_pulse),
      .delta_n   (delta_n),
      .cfg_err   (cfg_err)
   );

   int errors = 0, checks = 0;
   int cyc = 0, prev = 0, pulses = 0;
   bit boot = 0, pend = 0, first_len = 0, late_seen = 0, timed_out = 0;

   // bench model of the running configuration and modulator
   int m_n, m_f, m_m, m_o;
   bit m_vld = 0;
   int acc[3];
   int d2, d3, d33;
   int e_len, e_dn;
   bit e_err, e_apply;
   // window bookkeeping
   bit win_on = 0;
   int win_n, win_sum, win_hi;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                  tag, what, act, exp, cyc);
      end
   endtask

   function automatic int neg_of(input int o);
      return (o == 3) ? 3 : (o == 2) ? 1 : 0;
   endfunction

   task automatic model_bnd(input int n, input int f, input int m, input int o);
      bit ok;
      int x, s;
      int c[3];
      ok = (o != 0) && (m >= 2) && (f < m) && (n >= 2 + neg_of(o));
      e_err = !ok;
      if (ok && (!m_vld || n != m_n || f != m_f || m != m_m || o != m_o)) begin
         m_n = n; m_f = f; m_m = m; m_o = o; m_vld = 1;
         for (int k = 0; k < 3; k++) acc[k] = 0;
         d2 = 0; d3 = 0; d33 = 0;
         e_len = n; e_dn = 0; e_apply = 1;
      end else begin
         e_apply = 0;
         x = m_f;
         for (int k = 0; k < 3; k++) begin
            if (k < m_o) begin
               s = acc[k] + x;
               c[k] = (s >= m_m) ? 1 : 0;
               acc[k] = (c[k] == 1) ? s - m_m : s;
               x = acc[k];
            end else begin
               c[k] = 0;
               acc[k] = 0;
            end
         end
         e_dn = c[0] + c[1] - d2 + c[2] - 2 * d3 + d33;
         d2 = c[1]; d33 = d3; d3 = c[2];
         e_len = m_n + e_dn;
      end
   endtask

   task automatic window_add(input int len);
      int lo, hi, base, diff;
      if (!win_on) return;
      win_n++;
      win_sum += len;
      if (len == m_n + 1) win_hi++;
      if (win_n % m_m == 0) begin
         base = (win_n / m_m) * (m_m * m_n + m_f);
         diff = win_sum - base;
         lo = (m_o == 3) ? -1 : 0;
         hi = (m_o == 1) ? 0 : (m_o == 2) ? 1 : 2;
         // R6 long-run total over a multiple of M periods
         chk(diff >= lo && diff <= hi, "R6", "window total minus ideal", diff, 0);
         if (m_o == 1)
            // R3 count of N+1 periods in the window
            chk(win_hi == (win_n / m_m) * m_f, "R3", "long periods in window",
                win_hi, (win_n / m_m) * m_f);
      end
   endtask

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         if (cyc == 3) begin
            // R1 outputs during reset
            chk(div_pulse == 1'b0, "R1", "pulse in reset", int'(div_pulse), 0);
            chk(delta_n == 4'sd0, "R1", "delta_n in reset", int'(delta_n), 0);
            chk(cfg_err == 1'b0, "R1", "cfg_err in reset", int'(cfg_err), 0);
         end
      end else begin
         if (pend) begin
            pend = 0;
            if (e_apply)
               chk(int'(delta_n) == e_dn, "R7", "delta_n after apply", int'(delta_n), e_dn);
            else if (m_o == 3)
               chk(int'(delta_n) == e_dn, "R4", "delta_n sequence", int'(delta_n), e_dn);
            else
               chk(int'(delta_n) == e_dn, "R9", "delta_n continues", int'(delta_n), e_dn);
            chk(int'(cfg_err) == int'(e_err), "R8", "cfg_err", int'(cfg_err), int'(e_err));
            if (m_o == 1)
               chk(delta_n >= 0 && delta_n <= 1, "R3", "order 1 range", int'(delta_n), 0);
            else if (m_o == 2)
               chk(delta_n >= -1 && delta_n <= 2, "R5", "order 2 range", int'(delta_n), 0);
            else
               chk(delta_n >= -3 && delta_n <= 4, "R5", "order 3 range", int'(delta_n), 0);
         end
         if (boot) begin
            boot = 0;
            // R1 state at first sampling after release
            chk(div_pulse == 1'b0 && delta_n == 4'sd0 && cfg_err == 1'b0, "R1",
                "outputs after release", int'(div_pulse), 0);
            model_bnd(int'(n_int), int'(f_num), int'(m_mod), int'(order));
            prev = cyc; pend = 1; first_len = 1; late_seen = 0;
            win_on = e_apply; win_n = 0; win_sum = 0; win_hi = 0;
         end else if (div_pulse) begin
            if (first_len)
               chk(cyc - prev == e_len, "R1", "first pulse delay", cyc - prev, e_len);
            else if (e_apply)
               chk(cyc - prev == e_len, "R7", "period after apply", cyc - prev, e_len);
            else
               chk(cyc - prev == e_len, "R2", "period length", cyc - prev, e_len);
            if (!e_apply) window_add(cyc - prev);
            first_len = 0;
            model_bnd(int'(n_int), int'(f_num), int'(m_mod), int'(order));
            if (e_apply) begin
               win_on = 1; win_n = 0; win_sum = 0; win_hi = 0;
            end
            prev = cyc; pend = 1; pulses++; late_seen = 0;
         end else if (m_vld && !late_seen && (cyc - prev > e_len)) begin
            late_seen = 1;
            chk(0, "R2", "missing pulse", cyc - prev, e_len);
         end
      end
   end

   task automatic set_cfg(input int n, input int f, input int m, input int o);
      n_int = 8'(n); f_num = 8'(f); m_mod = 8'(m); order = 2'(o);
   endtask

   task automatic wait_pulses(input int k);
      int target;
      target = pulses + k;
      while (pulses < target) @(posedge clk);
      #1;
   endtask

   task automatic stimulus();
      int o, m, f, n, k, gap;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      boot = 1;
      // R3 directed: 1/100 fraction, order 1, full window
      wait_pulses(101);
      // order 2, three windows
      set_cfg(7, 3, 10, 2);
      wait_pulses(32);
      // order 3, odd modulus
      set_cfg(9, 13, 17, 3);
      wait_pulses(40);
      // R8 refused configurations while order 3 keeps running
      set_cfg(9, 20, 17, 3);
      wait_pulses(3);
      set_cfg(4, 1, 17, 3);
      wait_pulses(2);
      set_cfg(9, 1, 17, 0);
      wait_pulses(2);
      set_cfg(9, 0, 1, 1);
      wait_pulses(2);
      set_cfg(9, 13, 17, 3);
      wait_pulses(20);
      // smallest legal N per order, zero fraction
      set_cfg(5, 0, 7, 3);
      wait_pulses(10);
      set_cfg(3, 5, 6, 2);
      wait_pulses(14);
      set_cfg(2, 1, 2, 1);
      wait_pulses(6);
      // largest modulus, fraction just below it
      set_cfg(5, 254, 255, 3);
      wait_pulses(256);
      // largest N with positive excursions
      set_cfg(255, 200, 201, 3);
      wait_pulses(8);
      // random configurations changed at arbitrary clocks
      for (int i = 0; i < 24; i++) begin
         o = 1 + int'($urandom % 3);
         m = 2 + int'($urandom % 39);
         f = int'($urandom % 32'(m));
         n = 2 + neg_of(o) + int'($urandom % 14);
         if ($urandom % 5 == 0) begin
            set_cfg(n, m + int'($urandom % 4), m, o);
            wait_pulses(3);
         end else begin
            k = 1 + int'($urandom % 2);
            set_cfg(n, f, m, o);
            wait_pulses(k * m + 1);
         end
         gap = int'($urandom % 4);
         repeat (gap) @(posedge clk);
         #1;
      end
      wait_pulses(2);
   endtask

   initial begin
      fork
         stimulus();
         begin
            repeat (WDOG) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule